// File: doc/BRIEF.md
# Audio Output Mute and Lock Sequencer

This block sits at the serial output of a sample-rate converter and decides when converted samples may reach the output. It follows an active-low power-down request, a clock-lock flag, a rate-detected flag and an input-clock-present flag. Output words are forced to zero while the converter is powered down and while lock is being acquired. Real sample data is released only once lock and rate detection have both finished. A status output reports whether the path is unlocked.

Leaving power-down starts an acquisition window that is timed by a millisecond tick. If lock and rate detection do not both finish within 100 ticks, the window is abandoned. The path then stays muted and unlocked until the next power-down cycle. If the input clock disappears during normal operation, the output mutes at once and the block goes back to acquiring. Each new power-down request produces a one-cycle pulse that clears the downstream filter state.

The gate updates the output word only on a sample strobe, so a word is never cut partway through. The one exception is power-down, which clears the output without waiting for a strobe.

Top module: `audio_mute_seq`

## Requirements
- R1: Two clock cycles after `pwrDownN` is sampled low, `sampleOut` is zero and `unlocked` is high, whether or not a sample strobe occurs.
- R2: `filterRst` is high for exactly one cycle, in the cycle after the first clock edge at which `pwrDownN` is sampled low following a high level or reset.
- R3: After reset the block stays muted and unlocked, even with all status flags high, until `pwrDownN` has been low at least once and then returned high.
- R4: After power-down is released, samples are zero and `unlocked` is high. The block enters normal operation (`unlocked` low in the next cycle) only at an edge where `pllLocked`, `rateFound` and `clkPresent` are all high.
- R5: The acquisition window accepts lock after 99 `msTick` pulses. Once 100 pulses have occurred in it, lock is ignored, `unlocked` stays high and samples stay zero until the next power-down.
- R6: In normal operation, a word presented with `sampleValid` high appears unchanged on `sampleOut` one cycle later, with `sampleOutValid` high for that one cycle.
- R7: When `clkPresent` is sampled low with power-down released, `unlocked` is high in the next cycle and later samples are zero. When the clock returns with lock and rate still high, normal operation resumes.
- R8: Apart from power-down clearing, `sampleOut` changes only in the cycle after a `sampleValid` strobe; a change on `sampleIn` without a strobe has no effect.
- R9: `unlocked` is low only in normal operation; it is high throughout power-down and acquisition.
- R10: During reset, `sampleOut` is zero, `sampleOutValid` and `filterRst` are low and `unlocked` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrDownN | input | 1 | Active-low power-down request |
| pllLocked | input | 1 | Clock lock flag |
| rateFound | input | 1 | Input sample rate detected |
| clkPresent | input | 1 | Input clock present |
| msTick | input | 1 | One-cycle millisecond pulse |
| sampleValid | input | 1 | Sample boundary strobe |
| sampleIn | input | SAMPLE_W | Converted sample word |
| sampleOut | output | SAMPLE_W | Gated output word |
| sampleOutValid | output | 1 | Output word strobe |
| filterRst | output | 1 | One-cycle filter reset pulse |
| unlocked | output | 1 | High unless in normal operation |

## Verification
The properties assume that all inputs are synchronous to `clk` and are stable around its rising edge. They also assume that `msTick` and `sampleValid` are single-cycle strobes. The bench changes every input only at the falling edge and raises each strobe for exactly one cycle. It never changes the lock flags and a tick in the same cycle, so the timeout boundary at 99 and 100 ticks is unambiguous.

// File: rtl/ams_pkg.sv
package ams_pkg;

  typedef enum logic [1:0] {
    ST_PWRDN = 2'd0,
    ST_ACQ   = 2'd1,
    ST_RUN   = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic passReq;    // gate may release samples at the next boundary
    logic forceZero;  // clear output immediately
  } gateStrobe_t;

endpackage

// File: rtl/ams_tick_timer.sv
module ams_tick_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] tickCnt;

  assign expired = (tickCnt == LIMIT_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (clear) begin
      tickCnt <= '0;
    end else if (tick && !expired) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
endmodule

// File: rtl/ams_ctrl.sv
module ams_ctrl
  import ams_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrDownN,
  input  logic        pllLocked,
  input  logic        rateFound,
  input  logic        clkPresent,
  input  logic        msTick,
  output gateStrobe_t gateStb,
  output logic        filterRst,
  output logic        unlocked
);
  seqState_t state, stateNxt;
  logic      armed;
  logic      pdReqPrev;
  logic      windowExpired;
  logic      lockReady;

  assign lockReady = pllLocked && rateFound && clkPresent;

  ams_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (state != ST_ACQ),
    .tick    (msTick),
    .expired (windowExpired)
  );

  always_comb begin
    stateNxt = state;
    if (!pwrDownN) begin
      stateNxt = ST_PWRDN;
    end else begin
      unique case (state)
        ST_PWRDN: if (armed) stateNxt = ST_ACQ;
        ST_ACQ:   if (lockReady && !windowExpired) stateNxt = ST_RUN;
        ST_RUN:   if (!clkPresent) stateNxt = ST_ACQ;
        default:  stateNxt = ST_PWRDN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_PWRDN;
      armed     <= 1'b0;
      pdReqPrev <= 1'b0;
      filterRst <= 1'b0;
    end else begin
      state     <= stateNxt;
      pdReqPrev <= !pwrDownN;
      filterRst <= !pwrDownN && !pdReqPrev;
      if (!pwrDownN) armed <= 1'b1;
    end
  end

  assign unlocked          = (state != ST_RUN);
  assign gateStb.passReq   = (state == ST_RUN);
  assign gateStb.forceZero = (state == ST_PWRDN);
endmodule

// File: rtl/ams_gate.sv
module ams_gate
  import ams_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateStrobe_t         gateStb,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleOutValid
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut      <= '0;
      sampleOutValid <= 1'b0;
    end else begin
      sampleOutValid <= sampleValid;
      if (gateStb.forceZero) begin
        sampleOut <= '0;
      end else if (sampleValid) begin
        sampleOut <= gateStb.passReq ? sampleIn : '0;
      end
    end
  end
endmodule

// File: rtl/audio_mute_seq.sv
module audio_mute_seq
  import ams_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 24,
  parameter int unsigned TIMEOUT_TICKS = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrDownN,
  input  logic                pllLocked,
  input  logic                rateFound,
  input  logic                clkPresent,
  input  logic                msTick,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleOutValid,
  output logic                filterRst,
  output logic                unlocked
);
  gateStrobe_t gateStb;

  ams_ctrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrDownN   (pwrDownN),
    .pllLocked  (pllLocked),
    .rateFound  (rateFound),
    .clkPresent (clkPresent),
    .msTick     (msTick),
    .gateStb    (gateStb),
    .filterRst  (filterRst),
    .unlocked   (unlocked)
  );

  ams_gate #(.SAMPLE_W(SAMPLE_W)) u_gate (
    .clk            (clk),
    .rstN           (rstN),
    .gateStb        (gateStb),
    .sampleValid    (sampleValid),
    .sampleIn       (sampleIn),
    .sampleOut      (sampleOut),
    .sampleOutValid (sampleOutValid)
  );
endmodule

// File: rtl/ams_checker.sv
module ams_checker #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                pwrDownN,
  input logic                pllLocked,
  input logic                rateFound,
  input logic                clkPresent,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic                sampleOutValid,
  input logic                filterRst,
  input logic                unlocked,
  input logic                forceZero
);
  AST_PD_MUTES: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |-> ##2 (sampleOut == '0 && unlocked)); // R1

  AST_FRST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    filterRst |=> !filterRst); // R2

  AST_FRST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    filterRst |-> $past(!pwrDownN)); // R2

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlocked) |-> $past(pllLocked && rateFound && clkPresent && pwrDownN)); // R4

  AST_DATA_ONLY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (sampleOutValid && sampleOut != '0) |-> $past(!unlocked)); // R9

  AST_CLK_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDownN && !clkPresent) |=> unlocked); // R7

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !forceZero) |=> $stable(sampleOut)); // R8
endmodule

bind audio_mute_seq ams_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .pwrDownN       (pwrDownN),
  .pllLocked      (pllLocked),
  .rateFound      (rateFound),
  .clkPresent     (clkPresent),
  .sampleValid    (sampleValid),
  .sampleOut      (sampleOut),
  .sampleOutValid (sampleOutValid),
  .filterRst      (filterRst),
  .unlocked       (unlocked),
  .forceZero      (gateStb.forceZero)
);

// File: tb/audio_mute_seq_bench.sv
module audio_mute_seq_bench;
  localparam int unsigned W = 24;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN, pwrDownN, pllLocked, rateFound, clkPresent, msTick, sampleValid;
  logic [W-1:0] sampleIn, sampleOut;
  logic sampleOutValid, filterRst, unlocked;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expQ[$];
  string tagQ[$];
  logic [W-1:0] lastSent;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_mute_seq #(.SAMPLE_W(W), .TIMEOUT_TICKS(100)) u_audio_mute_seq (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .pllLocked(pllLocked),
    .rateFound(rateFound), .clkPresent(clkPresent), .msTick(msTick),
    .sampleValid(sampleValid), .sampleIn(sampleIn), .sampleOut(sampleOut),
    .sampleOutValid(sampleOutValid), .filterRst(filterRst), .unlocked(unlocked)
  );

  task automatic checkEq(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one sample strobe, expected result goes to the scoreboard
  task automatic sendSample(logic [W-1:0] v, bit pass, string req);
    @(negedge clk);
    sampleIn = v;
    sampleValid = 1'b1;
    expQ.push_back(pass ? v : '0);
    tagQ.push_back(req);
    if (pass) lastSent = v;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
    end
  endtask

  task automatic setLock(bit v);
    @(negedge clk);
    pllLocked = v;
    rateFound = v;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && sampleOutValid === 1'b1) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual=unexpected word %0h expected=none", sampleOut);
      end else begin
        checkEq(tagQ.pop_front(), 64'(sampleOut), 64'(expQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0; pwrDownN = 1; pllLocked = 0; rateFound = 0; clkPresent = 0;
    msTick = 0; sampleValid = 0; sampleIn = '0; lastSent = '0;
    cyc(3);
    checkEq("R10", 64'(unlocked), 1);
    checkEq("R10", 64'(sampleOut), 0);
    checkEq("R10", 64'(filterRst), 0);
    checkEq("R10", 64'(sampleOutValid), 0);

    // R3: no arming power-down yet
    @(negedge clk); rstN = 1; pllLocked = 1; rateFound = 1; clkPresent = 1;
    cyc(5);
    checkEq("R3", 64'(unlocked), 1);
    sendSample(24'h123456, 0, "R3");

    // R2: filter pulse
    @(negedge clk); pwrDownN = 0; pllLocked = 0; rateFound = 0;
    cyc(1);
    checkEq("R2", 64'(filterRst), 1);
    cyc(1);
    checkEq("R2", 64'(filterRst), 0);
    cyc(3);
    checkEq("R2", 64'(filterRst), 0);

    // R4: acquisition
    @(negedge clk); pwrDownN = 1;
    cyc(3);
    checkEq("R4", 64'(unlocked), 1);
    sendSample(24'h0000A5, 0, "R4");
    ticks(10);
    setLock(1);
    cyc(1);
    checkEq("R4", 64'(unlocked), 0);

    // R6: pass-through
    sendSample(24'hABCDEF, 1, "R6");
    sendSample(24'h800001, 1, "R6");
    sendSample(24'h7FFFFE, 1, "R6");

    // R8: no strobe, no change
    @(negedge clk); sampleIn = 24'h55AA55;
    cyc(3);
    checkEq("R8", 64'(sampleOut), 64'(lastSent));

    // R7: clock loss and recovery
    @(negedge clk); clkPresent = 0;
    cyc(1);
    checkEq("R7", 64'(unlocked), 1);
    sendSample(24'h111111, 0, "R7");
    @(negedge clk); clkPresent = 1;
    cyc(1);
    checkEq("R7", 64'(unlocked), 0);
    sendSample(24'h222222, 1, "R7");

    // R1: power-down from normal, no strobe
    @(negedge clk); pwrDownN = 0;
    cyc(1);
    checkEq("R2", 64'(filterRst), 1);
    checkEq("R1", 64'(unlocked), 1);
    cyc(1);
    checkEq("R1", 64'(sampleOut), 0);

    // R9: power-down keeps unlocked high with good flags
    cyc(3);
    checkEq("R9", 64'(unlocked), 1);

    // R5: 99 ticks still accepted
    setLock(0);
    @(negedge clk); pwrDownN = 1;
    cyc(2);
    ticks(99);
    setLock(1);
    cyc(2);
    checkEq("R5", 64'(unlocked), 0);

    // R5: 100 ticks expire the window
    @(negedge clk); pwrDownN = 0;
    cyc(2);
    setLock(0);
    @(negedge clk); pwrDownN = 1;
    cyc(2);
    ticks(100);
    cyc(2);
    setLock(1);
    cyc(3);
    checkEq("R5", 64'(unlocked), 1);
    sendSample(24'h333333, 0, "R5");

    // R5: next power-down cycle recovers
    @(negedge clk); pwrDownN = 0;
    cyc(2);
    @(negedge clk); pwrDownN = 1;
    cyc(3);
    checkEq("R5", 64'(unlocked), 0);
    sendSample(24'h444444, 1, "R5");

    cyc(4);
    checkEq("R6", 64'(expQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule